// File: doc/BRIEF.md
# Bit-Slice ALU with Shared Adder-Subtractor

This block is a purely combinational arithmetic and logic unit for operands of a parameterised width, four bits by default. The word is built from identical one-bit slices. Each slice forms six bitwise logic results and one full-adder bit. The carry ripples from the least significant slice to the most significant one. In each slice an 8-to-1 selector, driven by the 3-bit opcode, picks the result bit.

Addition and subtraction share one adder chain. There is no separate subtract input. The lowest opcode bit feeds an XOR in every slice, so each slice adds either B or the complement of B. That same bit is also the carry-in of the lowest slice. Subtraction is therefore A plus the complement of B plus one. The opcodes come in pairs, and each odd code gives the complemented form, or the subtract form, of the even code just below it.

Besides the result word, the unit drives a carry/borrow flag and a signed overflow flag. Both flags carry meaning only for the two arithmetic codes. For every logic code they are held at 0. The block has no clock and no state: its outputs depend only on the present inputs.

Top module: `bitslice_alu`

## Requirements
- R1: Opcode 000 gives Y = A AND B, and opcode 001 gives Y = NOT (A AND B), bit by bit.
- R2: Opcode 010 gives Y = A OR B, and opcode 011 gives Y = NOT (A OR B), bit by bit.
- R3: Opcode 100 gives Y = A XOR B, and opcode 101 gives Y = NOT (A XOR B), bit by bit.
- R4: Opcode 110 gives Y = (A + B) mod 2^W, with the carry flag equal to the carry out of the top bit.
- R5: Opcode 111 gives Y = (A − B) mod 2^W, with the carry flag equal to 1 exactly when A ≥ B unsigned, meaning no borrow.
- R6: For opcodes 110 and 111 the overflow flag is 1 exactly when the true signed (two's complement) result lies outside the range −2^(W−1) to 2^(W−1)−1.
- R7: For every opcode whose two upper bits are not both 1 (000 to 101), the carry flag and the overflow flag are both 0, whatever the operands.
- R8: For each logic pair {000,001}, {010,011}, {100,101}, the result of the odd code equals the bitwise complement of the result of the even code for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand, subtrahend for opcode 111 |
| op_i | input | 3 | Operation select; bit 0 is also the add/subtract control |
| y_o | output | W | Selected result word |
| cout_o | output | 1 | Carry (add) or no-borrow (subtract); 0 for logic codes |
| ovf_o | output | 1 | Signed overflow for arithmetic codes; 0 for logic codes |

## Verification
The assertions are immediate checks on a block with no clock. They assume that every input holds a known 0/1 value, and each check is skipped while any operand or opcode bit is unknown. They also assume that the outputs have settled for the present inputs. The bench keeps to both assumptions. It drives every input just after a rising edge and compares at the following falling edge. The inputs therefore stay stable and fully defined through each comparison, and the stimulus walks all 2^(2W+3) input combinations for the default width.

// File: rtl/bitslice_alu.sv
`timescale 1ns/1ps
module bitslice_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic         ctl;
  logic         arith;
  logic [W:0]   c;

  assign ctl   = op_i[0];
  assign arith = op_i[2] & op_i[1];
  assign c[0]  = ctl;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic       bx;
    logic       sum;
    logic [7:0] fn;

    assign bx       = b_i[i] ^ ctl;
    assign sum      = a_i[i] ^ bx ^ c[i];
    assign c[i+1]   = (a_i[i] & bx) | (c[i] & (a_i[i] ^ bx));

    assign fn[0] =   a_i[i] & b_i[i];
    assign fn[1] = ~(a_i[i] & b_i[i]);
    assign fn[2] =   a_i[i] | b_i[i];
    assign fn[3] = ~(a_i[i] | b_i[i]);
    assign fn[4] =   a_i[i] ^ b_i[i];
    assign fn[5] = ~(a_i[i] ^ b_i[i]);
    assign fn[6] = sum;
    assign fn[7] = sum;

    assign y_o[i] = fn[op_i];
  end

  assign cout_o = arith & c[W];
  assign ovf_o  = arith & (c[W] ^ c[W-1]);

endmodule

// File: rtl/bitslice_alu_chk.sv
`timescale 1ns/1ps
module bitslice_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] y_o,
  input logic         cout_o,
  input logic         ovf_o
);

  logic [W:0]   add_ext;
  logic [W-1:0] diff;
  logic [W-1:0] eff_b;
  logic         known;

  assign add_ext = {1'b0, a_i} + {1'b0, b_i};
  assign diff    = a_i - b_i;
  assign eff_b   = op_i[0] ? ~b_i : b_i;
  assign known   = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (known) begin
      AST_AND_PAIR: assert (op_i[2:1] != 2'b00 || y_o == (op_i[0] ? ~(a_i & b_i) : (a_i & b_i))) else $error("and pair"); // R1
      AST_OR_PAIR: assert (op_i[2:1] != 2'b01 || y_o == (op_i[0] ? ~(a_i | b_i) : (a_i | b_i))) else $error("or pair"); // R2
      AST_XOR_PAIR: assert (op_i[2:1] != 2'b10 || y_o == (op_i[0] ? ~(a_i ^ b_i) : (a_i ^ b_i))) else $error("xor pair"); // R3
      AST_ADD_SUM: assert (op_i != 3'b110 || {cout_o, y_o} == add_ext) else $error("add"); // R4
      AST_SUB_DIFF: assert (op_i != 3'b111 || (y_o == diff && cout_o == (a_i >= b_i))) else $error("sub"); // R5
      AST_SIGNED_OVF: assert (op_i[2:1] != 2'b11 || ovf_o == ((a_i[W-1] == eff_b[W-1]) && (y_o[W-1] != a_i[W-1]))) else $error("ovf"); // R6
      AST_NO_FLAGS: assert (op_i[2:1] == 2'b11 || (!cout_o && !ovf_o)) else $error("flags"); // R7
    end
  end

endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .y_o(y_o), .cout_o(cout_o), .ovf_o(ovf_o)
);

// File: tb/sim_bitslice_alu.sv
`timescale 1ns/1ps
module sim_bitslice_alu;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, y;
  logic [2:0] op;
  logic cout, ovf;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitslice_alu #(.W(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op), .y_o(y), .cout_o(cout), .ovf_o(ovf)
  );

  function automatic string req_of(int code);
    case (code)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R3";
      6:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d op=%0d)",
               req, what, act, exp, a, b, op);
    end
  endtask

  function automatic int sval(int v);
    return (v >= HALF) ? v - (1 << W) : v;
  endfunction

  initial begin
    int prev_y;
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(y), 0, "idle result");
    check("R7", int'(cout), 0, "idle carry");
    check("R7", int'(ovf), 0, "idle overflow");

    for (int ai = 0; ai <= M; ai++) begin
      for (int bi = 0; bi <= M; bi++) begin
        prev_y = 0;
        for (int k = 0; k < 8; k++) begin
          int ey, ec, eo, r;
          @(posedge clk);
          #1;
          a = W'(ai); b = W'(bi); op = 3'(k);
          ec = 0; eo = 0;
          case (k)
            0: ey = ai & bi;
            1: ey = ~(ai & bi) & M;
            2: ey = ai | bi;
            3: ey = ~(ai | bi) & M;
            4: ey = ai ^ bi;
            5: ey = ~(ai ^ bi) & M;
            6: begin
              ey = (ai + bi) & M;
              ec = (ai + bi) > M;
              r = sval(ai) + sval(bi);
              eo = (r >= HALF || r < -HALF);
            end
            default: begin
              ey = (ai - bi) & M;
              ec = ai >= bi;
              r = sval(ai) - sval(bi);
              eo = (r >= HALF || r < -HALF);
            end
          endcase
          @(negedge clk);
          check(req_of(k), int'(y), ey, "result");
          if (k < 6) begin
            check("R7", int'(cout), 0, "logic carry");
            check("R7", int'(ovf), 0, "logic overflow");
            if (k % 2 == 1) check("R8", int'(y), ~prev_y & M, "complement pair");
          end else begin
            check(req_of(k), int'(cout), ec, "carry");
            check("R6", int'(ovf), eo, "overflow");
          end
          prev_y = int'(y);
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule